// File: doc/BRIEF.md
# Vectored Interrupt Controller with Mask

This block arbitrates among 32 interrupt sources and hands the processor one request at a time. Each cycle it takes the request lines, applies a per-source enable mask and a global enable flag, and chooses the lowest-numbered eligible source. One clock later it pulses a take strobe together with the index it chose and the address of that index's slot in a handler table. The table sits at a fixed base, with one 32-bit word per entry, and addresses count in words. Lines 0 to 6 carry processor exceptions and lines 7 to 31 carry platform devices.

Every take has two side effects on the controller's own state. The global enable switches off, and the mask bit of the chosen index is cleared. Software must re-arm both itself. Software writes and reads the whole mask register, and it sets or clears the global enable through separate strobes.

Two kinds of request bypass the gating. Line 1, the non-maskable hardware-error line, is taken on its rising edge whatever the mask and global enable hold. A software trap names an index and is taken without regard to the mask or the global enable. Stacking of registers and the handler code are outside the block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, take_o is 0, mask_o is all zeros and gie_o is 0.
- R2: A source other than line 1 is taken only if, in the cycle it was sampled, its line was high, its mask bit was 1 and gie_o was 1. take_o rises at the clock edge that follows that cycle.
- R3: When several sources are eligible in the same cycle, take_idx_o reports the lowest index.
- R4: When take_o is 1, vec_addr_o equals TBL_BASE plus take_idx_o. Each table entry is one word, and addresses are word addresses (default base 0x00000F00).
- R5: The clock edge that raises take_o also clears gie_o. This clear wins over a gie_set_i in the same cycle.
- R6: The clock edge that raises take_o clears mask bit take_idx_o and leaves the other bits alone. The clear wins over a mask write in the same cycle for that bit.
- R7: When mask_we_i is 1, mask_wdata_i is loaded into the mask at the next edge, and mask_o shows it.
- R8: gie_set_i sets gie_o and gie_clr_i clears it. When both are 1, the clear wins.
- R9: Line 1 is taken on a 0-to-1 transition regardless of mask and gie_o. A line held high gives only one take.
- R10: A one-cycle sw_req_i with index sw_idx_i is taken regardless of mask and gie_o. It competes on index with the other eligible sources.
- R11: While gie_o is 0, maskable lines that are held high produce no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Level request lines, one per source |
| sw_req_i | input | 1 | Software trap strobe |
| sw_idx_i | input | log2(N_SRC) | Index raised by the software trap |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | N_SRC | Mask write data, 1 = source enabled |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| mask_o | output | N_SRC | Current mask register |
| gie_o | output | 1 | Current global enable |
| take_o | output | 1 | One-cycle strobe: a source was taken |
| take_idx_o | output | log2(N_SRC) | Index of the taken source |
| vec_addr_o | output | ADDR_W | Word address of that index's table entry |

## Verification
The bench raises every maskable line alone, then every pair of lines, and checks index, table address, and the cleared enable and mask bit on each take. A wrong priority encoder would report the higher index of a pair, and an off-by-one in the table arithmetic would show up on some of the 32 addresses. The bench holds a line high after a take and expects silence: a design that forgets to drop the global enable would take the same line again. It also sets the enable or rewrites the mask in the very cycle of a take, and a design that gives software the wrong precedence would leave those bits set. Line 1 is held high across several cycles to catch a level-triggered design that repeats the take. Software traps are fired with mask and enable at zero to catch a design that gates them.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned DEF_N_SRC    = 32;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_NMI_IDX  = 1;
  localparam logic [31:0] DEF_TBL_BASE = 32'h0000_0F00;

  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_SET  = 2'd1,
    GIE_CLR  = 2'd2
  } gie_op_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned NMI_IDX = 1,
  localparam int unsigned IDX_W  = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             gie_i,
  input  logic             sw_req_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  output logic [N_SRC-1:0] elig_o
);
  logic nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= irq_i[NMI_IDX];
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic hw_hit, sw_hit;
    if (g == NMI_IDX) begin : g_nmi
      // edge only: a held line must not re-enter forever
      assign hw_hit = irq_i[g] & ~nmi_q;
    end else begin : g_mask
      assign hw_hit = irq_i[g] & mask_i[g] & gie_i;
    end
    assign sw_hit    = sw_req_i & (sw_idx_i == IDX_W'(g));
    assign elig_o[g] = hw_hit | sw_hit;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC  = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (elig_i[k]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] take_idx_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             gie_o
);
  logic [N_SRC-1:0] mask_q, mask_d;
  logic             gie_q, gie_d;
  gie_op_e          gie_op;

  always_comb begin
    mask_d = mask_we_i ? mask_wdata_i : mask_q;
    if (take_i) mask_d[take_idx_i] = 1'b0;
  end

  always_comb begin
    if (take_i || gie_clr_i) gie_op = GIE_CLR;
    else if (gie_set_i)      gie_op = GIE_SET;
    else                     gie_op = GIE_HOLD;
    unique case (gie_op)
      GIE_SET: gie_d = 1'b1;
      GIE_CLR: gie_d = 1'b0;
      default: gie_d = gie_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      gie_q  <= gie_d;
    end
  end

  assign mask_o = mask_q;
  assign gie_o  = gie_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned          N_SRC    = DEF_N_SRC,
  parameter int unsigned          ADDR_W   = DEF_ADDR_W,
  parameter int unsigned          NMI_IDX  = DEF_NMI_IDX,
  parameter logic [ADDR_W-1:0]    TBL_BASE = ADDR_W'(DEF_TBL_BASE)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SRC-1:0]           irq_i,
  input  logic                       sw_req_i,
  input  logic [$clog2(N_SRC)-1:0]   sw_idx_i,
  input  logic                       mask_we_i,
  input  logic [N_SRC-1:0]           mask_wdata_i,
  input  logic                       gie_set_i,
  input  logic                       gie_clr_i,
  output logic [N_SRC-1:0]           mask_o,
  output logic                       gie_o,
  output logic                       take_o,
  output logic [$clog2(N_SRC)-1:0]   take_idx_o,
  output logic [ADDR_W-1:0]          vec_addr_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] elig;
  logic             any;
  logic [IDX_W-1:0] pick_idx;

  irq_gate #(.N_SRC(N_SRC), .NMI_IDX(NMI_IDX)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .mask_i  (mask_o),
    .gie_i   (gie_o),
    .sw_req_i(sw_req_i),
    .sw_idx_i(sw_idx_i),
    .elig_o  (elig)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .elig_i(elig),
    .any_o (any),
    .idx_o (pick_idx)
  );

  irq_state #(.N_SRC(N_SRC)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (mask_we_i),
    .mask_wdata_i(mask_wdata_i),
    .gie_set_i   (gie_set_i),
    .gie_clr_i   (gie_clr_i),
    .take_i      (any),
    .take_idx_i  (pick_idx),
    .mask_o      (mask_o),
    .gie_o       (gie_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      take_idx_o <= '0;
      vec_addr_o <= TBL_BASE;
    end else begin
      take_o <= any;
      if (any) begin
        take_idx_o <= pick_idx;
        vec_addr_o <= TBL_BASE + ADDR_W'(pick_idx);
      end
    end
  end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int unsigned       N_SRC    = 32,
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       NMI_IDX  = 1,
  parameter logic [ADDR_W-1:0] TBL_BASE = '0,
  localparam int unsigned      IDX_W    = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] irq_i,
  input logic             sw_req_i,
  input logic             gie_set_i,
  input logic [N_SRC-1:0] mask_o,
  input logic             gie_o,
  input logic             take_o,
  input logic [IDX_W-1:0] take_idx_o,
  input logic [ADDR_W-1:0] vec_addr_o
);
  logic [N_SRC-1:0] low_m;
  assign low_m = (N_SRC'(1) << take_idx_o) - N_SRC'(1);

  p_vec_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> vec_addr_o == TBL_BASE + ADDR_W'(take_idx_o));

  p_gie_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !gie_o);

  p_mask_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !mask_o[take_idx_o]);

  p_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_idx_o != IDX_W'(NMI_IDX) && !$past(sw_req_i)) |->
      ($past(gie_o) && ((($past(mask_o & irq_i)) >> take_idx_o) & N_SRC'(1)) != '0));

  p_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !$past(sw_req_i) && take_idx_o != IDX_W'(NMI_IDX)) |->
      (($past(irq_i & mask_o & {N_SRC{gie_o}}) & low_m) == '0));

  p_gie_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gie_o) |-> $past(gie_set_i));
endmodule

bind irq_vec_ctrl irq_vec_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .NMI_IDX(NMI_IDX), .TBL_BASE(TBL_BASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .sw_req_i  (sw_req_i),
  .gie_set_i (gie_set_i),
  .mask_o    (mask_o),
  .gie_o     (gie_o),
  .take_o    (take_o),
  .take_idx_o(take_idx_o),
  .vec_addr_o(vec_addr_o)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int unsigned N = 32;
  localparam logic [31:0] BASE = 32'h0000_0F00;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic        sw_req_i = 1'b0;
  logic [4:0]  sw_idx_i = '0;
  logic        mask_we_i = 1'b0;
  logic [N-1:0] mask_wdata_i = '0;
  logic        gie_set_i = 1'b0;
  logic        gie_clr_i = 1'b0;
  logic [N-1:0] mask_o;
  logic        gie_o;
  logic        take_o;
  logic [4:0]  take_idx_o;
  logic [31:0] vec_addr_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  irq_vec_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .sw_req_i(sw_req_i),
    .sw_idx_i(sw_idx_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .mask_o(mask_o),
    .gie_o(gie_o), .take_o(take_o), .take_idx_o(take_idx_o),
    .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  // arm mask and global enable, with no request lines high
  task automatic arm(input logic [N-1:0] m);
    irq_i = '0; mask_we_i = 1'b1; mask_wdata_i = m; gie_set_i = 1'b1;
    cyc();
    mask_we_i = 1'b0; gie_set_i = 1'b0;
  endtask

  task automatic expect_take(input int idx, input logic [N-1:0] m_exp, input string req);
    chk(take_o == 1'b1, req, {31'd0, take_o}, 32'd1);
    chk(take_idx_o == 5'(idx), req, {27'd0, take_idx_o}, idx);
    chk(vec_addr_o == BASE + idx, "R4", vec_addr_o, BASE + idx);
    chk(gie_o == 1'b0, "R5", {31'd0, gie_o}, 32'd0);
    chk(mask_o == m_exp, "R6", mask_o, m_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] all1;
    all1 = '1;
    cyc(); cyc();
    // R1
    chk(take_o == 1'b0, "R1", {31'd0, take_o}, 32'd0);
    chk(mask_o == '0, "R1", mask_o, 32'd0);
    chk(gie_o == 1'b0, "R1", {31'd0, gie_o}, 32'd0);
    rst_ni = 1'b1;
    cyc();

    // R7 mask write and readback
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] v;
      v = (p == 0) ? 32'hA5A5_5A5A : (p == 1) ? 32'h0000_0001 :
          (p == 2) ? 32'hFFFF_FFFF : 32'h1234_8765;
      mask_we_i = 1'b1; mask_wdata_i = v;
      cyc();
      mask_we_i = 1'b0;
      chk(mask_o == v, "R7", mask_o, v);
    end

    // R8 enable set, clear, both
    gie_set_i = 1'b1; cyc(); gie_set_i = 1'b0;
    chk(gie_o == 1'b1, "R8", {31'd0, gie_o}, 32'd1);
    gie_clr_i = 1'b1; cyc(); gie_clr_i = 1'b0;
    chk(gie_o == 1'b0, "R8", {31'd0, gie_o}, 32'd0);
    gie_set_i = 1'b1; cyc();
    gie_set_i = 1'b1; gie_clr_i = 1'b1; cyc();
    gie_set_i = 1'b0; gie_clr_i = 1'b0;
    chk(gie_o == 1'b0, "R8", {31'd0, gie_o}, 32'd0);

    // R11 enable off: maskable lines ignored
    mask_we_i = 1'b1; mask_wdata_i = all1; cyc(); mask_we_i = 1'b0;
    irq_i = 32'hFFFF_FFFD;
    for (int c = 0; c < 4; c++) begin
      cyc();
      chk(take_o == 1'b0, "R11", {31'd0, take_o}, 32'd0);
    end
    chk(mask_o == all1, "R11", mask_o, all1);
    irq_i = '0; cyc();

    // R2 single source sweep, then held line gives no second take (R11)
    for (int i = 0; i < N; i++) begin
      if (i == 1) continue;
      arm(all1);
      irq_i = N'(1) << i;
      cyc();
      expect_take(i, all1 & ~(N'(1) << i), "R2");
      cyc();
      chk(take_o == 1'b0, "R11", {31'd0, take_o}, 32'd0);
      irq_i = '0; cyc();
    end

    // R2 masked-off source is not taken
    for (int i = 0; i < N; i++) begin
      if (i == 1) continue;
      arm(all1 & ~(N'(1) << i));
      irq_i = N'(1) << i;
      cyc();
      chk(take_o == 1'b0, "R2", {31'd0, take_o}, 32'd0);
      chk(gie_o == 1'b1, "R2", {31'd0, gie_o}, 32'd1);
      irq_i = '0; cyc();
    end

    // R3 every pair: lower index wins
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (i == 1 || j == 1) continue;
        arm(all1);
        irq_i = (N'(1) << i) | (N'(1) << j);
        cyc();
        chk(take_o && take_idx_o == 5'(i), "R3", {27'd0, take_idx_o}, i);
        irq_i = '0; cyc();
      end
    end

    // R5 take beats same-cycle enable set; R6 take beats same-cycle mask write
    arm(all1);
    irq_i = 32'h0000_0100; gie_set_i = 1'b1; mask_we_i = 1'b1; mask_wdata_i = all1;
    cyc();
    gie_set_i = 1'b0; mask_we_i = 1'b0; irq_i = '0;
    chk(gie_o == 1'b0, "R5", {31'd0, gie_o}, 32'd0);
    chk(mask_o == 32'hFFFF_FEFF, "R6", mask_o, 32'hFFFF_FEFF);
    cyc();

    // R9 line 1 edge-taken with mask and enable off
    mask_we_i = 1'b1; mask_wdata_i = '0; gie_clr_i = 1'b1; cyc();
    mask_we_i = 1'b0; gie_clr_i = 1'b0;
    irq_i = 32'h0000_0002;
    cyc();
    chk(take_o && take_idx_o == 5'd1, "R9", {27'd0, take_idx_o}, 32'd1);
    chk(vec_addr_o == BASE + 1, "R9", vec_addr_o, BASE + 1);
    for (int c = 0; c < 3; c++) begin
      cyc();
      chk(take_o == 1'b0, "R9", {31'd0, take_o}, 32'd0);
    end
    irq_i = '0; cyc();
    irq_i = 32'h0000_0002; cyc();
    chk(take_o == 1'b1, "R9", {31'd0, take_o}, 32'd1);
    irq_i = '0; cyc();

    // R10 software trap every index with mask and enable off
    for (int k = 0; k < N; k++) begin
      sw_req_i = 1'b1; sw_idx_i = 5'(k);
      cyc();
      sw_req_i = 1'b0;
      chk(take_o && take_idx_o == 5'(k), "R10", {27'd0, take_idx_o}, k);
      chk(vec_addr_o == BASE + k, "R10", vec_addr_o, BASE + k);
      cyc();
      chk(take_o == 1'b0, "R10", {31'd0, take_o}, 32'd0);
    end

    // R10 trap competes on index: line 3 beats trap 10, trap 2 beats line 9
    arm(all1);
    irq_i = 32'h0000_0008; sw_req_i = 1'b1; sw_idx_i = 5'd10;
    cyc();
    sw_req_i = 1'b0; irq_i = '0;
    chk(take_o && take_idx_o == 5'd3, "R10", {27'd0, take_idx_o}, 32'd3);
    cyc();
    arm(all1);
    irq_i = 32'h0000_0200; sw_req_i = 1'b1; sw_idx_i = 5'd2;
    cyc();
    sw_req_i = 1'b0; irq_i = '0;
    chk(take_o && take_idx_o == 5'd2, "R10", {27'd0, take_idx_o}, 32'd2);
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule